// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is a single capture channel of a timer/counter. It watches one of two trigger lines, either an external pin or an internal event line, and on the active edge of the chosen line it takes a snapshot of a free-running counter value supplied from outside. Snapshots go into a two-entry queue. The first entry is a hidden staging buffer that software cannot read. The second is the readable capture register.

When a snapshot reaches the readable register, the channel raises an interrupt flag and sends a one-cycle request pulse that an event router or DMA engine can use. Software collects values by reading the capture register. That read frees the register, and any staged value moves up on the same edge. If a trigger arrives while both entries are occupied, the snapshot is lost and a sticky overflow flag is set.

Configuration sets the following:
- whether the channel captures at all;
- which source triggers it;
- the polarity of each source;
- the capture mode, which limits the sources that are legal;
- a global enable for the event input.

Top module: `cap_channel`

## Requirements
- R1: While `cap_en` is 0, no trigger on either source produces a capture. The flag, the request pulse and the capture register all stay unchanged.
- R2: `src_pin` = 1 selects the pin as the trigger source and `src_pin` = 0 selects the event line. Edges on the source that is not selected are ignored.
- R3: A pin trigger is accepted only when `mode` is 2'b00 (event) or 2'b01 (time-stamp). In mode 2'b10 (pulse-width/period) and in mode 2'b11 (reserved) it is ignored.
- R4: An event-line trigger is accepted in mode 2'b00, mode 2'b01 and mode 2'b10. In mode 2'b11 it is ignored.
- R5: An event-line trigger is accepted only while `evt_in_en` is 1.
- R6: The active edge is rising when the source's invert bit (`pin_inv` or `evt_inv`) is 0, and falling when that bit is 1. The opposite edge never captures.
- R7: The trigger passes through a two-flop synchronizer. The `count` value is sampled at the third rising clock edge after the trigger input changes. If the capture register is empty, that value appears on `cc_data` with `irq_flag` = 1 after the fourth edge.
- R8: The two entries act as a first-in first-out queue. A read (`cc_rd` = 1 while `irq_flag` = 1) that finds a staged value loads that value into `cc_data` on the same edge, and `irq_flag` stays 1.
- R9: Each move of a value into the capture register produces `dma_req` = 1 for exactly the following cycle. A read with nothing staged clears `irq_flag` and leaves `cc_data` unchanged.
- R10: A capture that arrives while both entries hold data and no read is in progress is discarded. It sets `ovf_flag`, which stays 1 until reset, and both held values are kept.
- R11: After reset, `cc_data` is 0 and `irq_flag`, `dma_req` and `ovf_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| count | input | CNT_W | Free-running counter value to snapshot |
| trig_pin | input | 1 | Trigger from the external pin (asynchronous) |
| trig_evt | input | 1 | Trigger from the internal event line (asynchronous) |
| cap_en | input | 1 | Capture enable for this channel |
| src_pin | input | 1 | 1 = pin source, 0 = event source |
| evt_in_en | input | 1 | Global enable for the event input |
| pin_inv | input | 1 | Inverts the active polarity of the pin |
| evt_inv | input | 1 | Inverts the active polarity of the event line |
| mode | input | 2 | 00 event, 01 time-stamp, 10 pulse-width/period, 11 reserved |
| cc_rd | input | 1 | Read strobe for the capture register |
| cc_data | output | CNT_W | Readable capture register |
| irq_flag | output | 1 | Capture register holds unread data |
| dma_req | output | 1 | One-cycle request pulse on each move into the register |
| ovf_flag | output | 1 | Sticky flag for a dropped capture |

## Verification
The assertions assume that the configuration inputs and `count` change only between clock edges. They also assume that an invert bit is never toggled while its trigger line is held at a level that would make the change look like an edge. The stimulus drives every input on the falling clock edge. Whenever it changes an invert bit, it moves the matching trigger line to the new idle level at the same moment. It keeps `count` constant from the moment a trigger is raised until the snapshot is taken. It leaves enough cycles between triggers for every edge to be detected separately.

// File: rtl/cap_channel_pkg.sv
package cap_channel_pkg;

  typedef enum logic [1:0] {
    CM_EVENT = 2'b00,
    CM_STAMP = 2'b01,
    CM_PULSE = 2'b10,
    CM_RSVD  = 2'b11
  } cap_mode_e;

  // Pin triggers are legal only in the event and time-stamp modes.
  function automatic logic pin_mode_ok(input cap_mode_e m);
    return (m == CM_EVENT) || (m == CM_STAMP);
  endfunction

  // Event-line triggers are legal in every mode except the reserved one.
  function automatic logic evt_mode_ok(input cap_mode_e m);
    return (m == CM_EVENT) || (m == CM_STAMP) || (m == CM_PULSE);
  endfunction

  // A staged value moves up when the register is empty or is being read.
  function automatic logic fifo_move(input logic stage_full,
                                     input logic reg_full,
                                     input logic rd);
    return stage_full && (!reg_full || rd);
  endfunction

endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic inv,
  output logic act_edge
);
  // The polarity is applied before synchronizing, so that a line and its
  // invert bit changing together do not look like an edge.
  logic [STAGES-1:0] chain;
  logic              prev_lvl;
  logic              lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], raw ^ inv};
  end

  assign lvl = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else        prev_lvl <= lvl;
  end

  assign act_edge = lvl && !prev_lvl;

  // R6: a detected edge lasts a single cycle
  a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    act_edge |=> !act_edge);

endmodule

// File: rtl/cap_trig_sel.sv
module cap_trig_sel
  import cap_channel_pkg::*;
(
  input  logic      pin_edge,
  input  logic      evt_edge,
  input  logic      cap_en,
  input  logic      src_pin,
  input  logic      evt_in_en,
  input  cap_mode_e mode,
  output logic      fire
);
  logic pin_ok;
  logic evt_ok;

  assign pin_ok = src_pin && pin_mode_ok(mode) && pin_edge;
  assign evt_ok = !src_pin && evt_in_en && evt_mode_ok(mode) && evt_edge;
  assign fire   = cap_en && (pin_ok || evt_ok);

endmodule

// File: rtl/cap_fifo2.sv
module cap_fifo2
  import cap_channel_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         rd,
  output logic [W-1:0] dout,
  output logic         flag,
  output logic         req,
  output logic         ovf,
  output logic         xfer
);
  logic [W-1:0] stage_q;
  logic         stage_vld;
  logic [W-1:0] reg_q;
  logic         reg_vld;
  logic         accept;
  logic         drop;

  assign xfer   = fifo_move(stage_vld, reg_vld, rd);
  assign accept = push && (!stage_vld || xfer);
  assign drop   = push && !accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      stage_vld <= 1'b0;
    end else if (accept) begin
      stage_q   <= din;
      stage_vld <= 1'b1;
    end else if (xfer) begin
      stage_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q   <= '0;
      reg_vld <= 1'b0;
    end else if (xfer) begin
      reg_q   <= stage_q;
      reg_vld <= 1'b1;
    end else if (rd) begin
      reg_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      ovf <= 1'b0;
    end else begin
      req <= xfer;
      if (drop) ovf <= 1'b1;
    end
  end

  assign dout = reg_q;
  assign flag = reg_vld;

  // R8: a staged value with an empty register is promoted on the next edge
  a_r8_refill: assert property (@(posedge clk) disable iff (!rst_n)
    stage_vld && !reg_vld |=> reg_vld);

  // R8: without a read, unread data and its flag are held
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_vld && !rd |=> reg_vld && $stable(reg_q));

  // R9: every promotion raises the request and the flag
  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> req && flag);

  // R9: a read with nothing staged clears the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd && reg_vld && !stage_vld |=> !flag);

  // R10: a capture into a full queue sets overflow
  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    push && stage_vld && reg_vld && !rd |=> ovf);

  // R10: overflow is sticky
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_channel_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             trig_pin,
  input  logic             trig_evt,
  input  logic             cap_en,
  input  logic             src_pin,
  input  logic             evt_in_en,
  input  logic             pin_inv,
  input  logic             evt_inv,
  input  logic [1:0]       mode,
  input  logic             cc_rd,
  output logic [CNT_W-1:0] cc_data,
  output logic             irq_flag,
  output logic             dma_req,
  output logic             ovf_flag
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] raw_lines;
  logic [NSRC-1:0] inv_bits;
  logic [NSRC-1:0] edges;
  logic            pin_edge;
  logic            evt_edge;
  logic            cap_fire;
  logic            xfer;
  cap_mode_e       mode_e;

  assign raw_lines = {trig_evt, trig_pin};
  assign inv_bits  = {evt_inv, pin_inv};
  assign mode_e    = cap_mode_e'(mode);

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    cap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (raw_lines[s]),
      .inv      (inv_bits[s]),
      .act_edge (edges[s])
    );
  end

  assign pin_edge = edges[0];
  assign evt_edge = edges[1];

  cap_trig_sel u_sel (
    .pin_edge  (pin_edge),
    .evt_edge  (evt_edge),
    .cap_en    (cap_en),
    .src_pin   (src_pin),
    .evt_in_en (evt_in_en),
    .mode      (mode_e),
    .fire      (cap_fire)
  );

  cap_fifo2 #(.W(CNT_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (cap_fire),
    .din   (count),
    .rd    (cc_rd),
    .dout  (cc_data),
    .flag  (irq_flag),
    .req   (dma_req),
    .ovf   (ovf_flag),
    .xfer  (xfer)
  );

  // R1: a disabled channel never captures
  a_r1_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |-> !cap_fire);

  // R3: pin triggers are blocked in the pulse-width and reserved modes
  a_r3_pin_mode: assert property (@(posedge clk) disable iff (!rst_n)
    src_pin && mode[1] |-> !cap_fire);

  // R4: event triggers are blocked in the reserved mode
  a_r4_evt_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !src_pin && (mode == 2'b11) |-> !cap_fire);

  // R5: event triggers need the global event-input enable
  a_r5_evt_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !src_pin && !evt_in_en |-> !cap_fire);

  // R2: a capture always comes from an edge on the selected source
  a_r2_source: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |-> (src_pin ? pin_edge : evt_edge));

  // R9: the request pulse follows a promotion only
  a_r9_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> !dma_req);

endmodule

// File: tb/cap_channel_bench.sv
module cap_channel_bench;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] count = '0;
  logic          trig_pin = 1'b0, trig_evt = 1'b0;
  logic          cap_en = 1'b1, src_pin = 1'b1, evt_in_en = 1'b1;
  logic          pin_inv = 1'b0, evt_inv = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          cc_rd = 1'b0;
  logic [CW-1:0] cc_data;
  logic          irq_flag, dma_req, ovf_flag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cap_channel #(.CNT_W(CW)) u_cap_channel (
    .clk(clk), .rst_n(rst_n), .count(count), .trig_pin(trig_pin),
    .trig_evt(trig_evt), .cap_en(cap_en), .src_pin(src_pin),
    .evt_in_en(evt_in_en), .pin_inv(pin_inv), .evt_inv(evt_inv),
    .mode(mode), .cc_rd(cc_rd), .cc_data(cc_data), .irq_flag(irq_flag),
    .dma_req(dma_req), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Pulse the chosen line to its active level and back, then let the queue settle.
  task automatic fire(input bit use_pin, input logic [CW-1:0] val);
    count = val;
    if (use_pin) trig_pin = ~pin_inv; else trig_evt = ~evt_inv;
    cyc(3);
    if (use_pin) trig_pin = pin_inv; else trig_evt = evt_inv;
    cyc(4);
  endtask

  task automatic do_read();
    cc_rd = 1'b1;
    cyc(1);
    cc_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 data", cc_data, 0);
    chk("R11 irq", irq_flag, 0);
    chk("R11 req", dma_req, 0);
    chk("R11 ovf", ovf_flag, 0);
  endtask

  task automatic t_latency();
    count = 16'h1234;
    trig_pin = 1'b1;
    cyc(3);
    chk("R7 no flag after third edge", irq_flag, 0);
    cyc(1);
    chk("R7 flag after fourth edge", irq_flag, 1);
    chk("R7 data", cc_data, 16'h1234);
    chk("R9 req pulse", dma_req, 1);
    cyc(1);
    chk("R9 req one cycle", dma_req, 0);
    trig_pin = 1'b0;
    count = 16'h5555;
    do_read();
    chk("R9 read clears flag", irq_flag, 0);
    chk("R9 data held after read", cc_data, 16'h1234);
    cyc(5);
    chk("R6 falling edge ignored", irq_flag, 0);
  endtask

  task automatic t_invert();
    pin_inv = 1'b1; trig_pin = 1'b1;
    cyc(5);
    chk("R6 inv change no capture", irq_flag, 0);
    fire(1'b1, 16'h00AA);
    chk("R6 falling edge captures", cc_data, 16'h00AA);
    chk("R6 flag", irq_flag, 1);
    do_read();
    pin_inv = 1'b0; trig_pin = 1'b0;
    cyc(5);
    chk("R6 restore no capture", irq_flag, 0);
  endtask

  task automatic t_fifo();
    fire(1'b1, 16'h0A01);
    fire(1'b1, 16'h0B02);
    chk("R8 first out", cc_data, 16'h0A01);
    chk("R10 no ovf at two", ovf_flag, 0);
    do_read();
    chk("R8 refill value", cc_data, 16'h0B02);
    chk("R8 flag stays", irq_flag, 1);
    chk("R9 req on refill", dma_req, 1);
    do_read();
    chk("R9 flag cleared", irq_flag, 0);
  endtask

  task automatic t_overflow();
    fire(1'b1, 16'h0C03);
    fire(1'b1, 16'h0D04);
    fire(1'b1, 16'h0E05);
    chk("R10 ovf set", ovf_flag, 1);
    chk("R10 head kept", cc_data, 16'h0C03);
    do_read();
    chk("R10 second kept", cc_data, 16'h0D04);
    do_read();
    chk("R10 drained", irq_flag, 0);
    cyc(3);
    chk("R10 ovf sticky", ovf_flag, 1);
  endtask

  task automatic t_disable();
    cap_en = 1'b0;
    fire(1'b1, 16'h1111);
    chk("R1 pin blocked", irq_flag, 0);
    src_pin = 1'b0;
    fire(1'b0, 16'h1112);
    chk("R1 event blocked", irq_flag, 0);
    cap_en = 1'b1; src_pin = 1'b1;
  endtask

  task automatic t_source();
    fire(1'b0, 16'h2221);
    chk("R2 event ignored when pin selected", irq_flag, 0);
    src_pin = 1'b0;
    fire(1'b1, 16'h2222);
    chk("R2 pin ignored when event selected", irq_flag, 0);
    fire(1'b0, 16'h2223);
    chk("R2 event captured", cc_data, 16'h2223);
    do_read();
    src_pin = 1'b1;
  endtask

  task automatic t_pin_modes();
    mode = 2'b10;
    fire(1'b1, 16'h3331);
    chk("R3 pin blocked mode 10", irq_flag, 0);
    mode = 2'b11;
    fire(1'b1, 16'h3332);
    chk("R3 pin blocked mode 11", irq_flag, 0);
    mode = 2'b01;
    fire(1'b1, 16'h3333);
    chk("R3 pin accepted mode 01", cc_data, 16'h3333);
    do_read();
    mode = 2'b00;
  endtask

  task automatic t_evt_modes();
    src_pin = 1'b0;
    mode = 2'b10;
    fire(1'b0, 16'h4441);
    chk("R4 event accepted mode 10", cc_data, 16'h4441);
    do_read();
    mode = 2'b11;
    fire(1'b0, 16'h4442);
    chk("R4 event blocked mode 11", irq_flag, 0);
    mode = 2'b00;
    evt_in_en = 1'b0;
    fire(1'b0, 16'h5551);
    chk("R5 event needs enable", irq_flag, 0);
    evt_in_en = 1'b1;
    evt_inv = 1'b1; trig_evt = 1'b1;
    cyc(5);
    fire(1'b0, 16'h6661);
    chk("R6 event falling captures", cc_data, 16'h6661);
    do_read();
    evt_inv = 1'b0; trig_evt = 1'b0;
    src_pin = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_latency();
    t_invert();
    t_fifo();
    t_overflow();
    t_disable();
    t_source();
    t_pin_modes();
    t_evt_modes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule